// File: doc/BRIEF.md
# Interrupt and Exception Arbiter

This block sits at the instruction-boundary point of a small processor pipeline. Each cycle in which the execute stage reports that an instruction has retired or been aborted, the arbiter looks at every event raised for that instruction and at the interrupt requests outstanding at that moment. It chooses exactly one event and sends one registered redirect pulse to the front end. The pulse carries the 8-bit handler vector, the return address to save, a flag that says whether that address can be used, and a code that says what kind of event was taken.

The execute stage reports synchronous exceptions on a set of lanes. Each lane carries its own class and its own vector. Non-maskable requests are latched internally and stay blocked after one is taken, until an interrupt-return indication arrives. A maskable request that wins runs an acknowledge handshake, which fetches its vector from an external controller. The pipeline is expected to stall while the handshake is open. The block does not do table lookup, stack pushes or privilege checks.

Top module: `irq_exc_arbiter`

## Requirements
- R1: A redirect pulse appears only in the cycle after a cycle with `boundary` high while no acknowledge is open, or in the cycle after `vec_valid` is seen while an acknowledge is open. Events are never taken at any other time.
- R2: Exception lanes carry a class code: 0 abort, 1 fault, 2 debug trap, 3 software trap. The priority order, highest first, is abort, fault, debug trap, software trap, then the non-maskable request, then the maskable request.
- R3: When two lanes of the same class are valid at once, the lane with the lower vector number wins. On an equal vector, the lower lane index wins.
- R4: While `if_flag` is low, `intr_in` is ignored. No acknowledge starts and no redirect is produced for it.
- R5: A maskable request that wins raises `ack_req` in the next cycle and holds it until `vec_valid` is seen. The redirect follows one cycle later, carrying `vec_in`, kind 3, and the `next_pc` captured at the accepting boundary. `boundary` and the exception lanes are ignored while `ack_req` is high.
- R6: A taken non-maskable request redirects with vector 2 and kind 3. It saves `next_pc` and performs no acknowledge.
- R7: After a non-maskable request is taken, later ones are held pending and not taken until `iret` has been seen. The first boundary after that takes the held request.
- R8: The redirect kind code is 0 for a fault, 1 for a trap (debug or software) and 3 for an interrupt. A fault saves `cur_pc`. Traps and interrupts save `next_pc`. In all three cases `ret_valid` is 1.
- R9: An abort redirects with kind 2, `ret_valid` low and a return address of zero.
- R10: Exceptions that lose at a boundary are discarded and never signalled later. A non-maskable request that loses stays pending, and so does a maskable request that is still asserted; each is taken at a later boundary.
- R11: After reset there is no redirect and `ack_req` is low. No non-maskable request is pending and none is blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary | input | 1 | Instruction retired or aborted this cycle |
| cur_pc | input | AW | Address of the instruction at the boundary |
| next_pc | input | AW | Address of the next instruction to execute |
| exc_valid | input | N_EXC | Per-lane exception request |
| exc_class | input | 2*N_EXC | Per-lane class code (2 bits per lane) |
| exc_vec | input | 8*N_EXC | Per-lane vector (8 bits per lane) |
| nmi_in | input | 1 | Non-maskable request pulse |
| intr_in | input | 1 | Maskable request level |
| if_flag | input | 1 | Maskable interrupt enable |
| iret | input | 1 | Interrupt return executed |
| ack_req | output | 1 | Acknowledge cycle open for a maskable request |
| vec_valid | input | 1 | External vector is present |
| vec_in | input | 8 | External vector number |
| redirect | output | 1 | One-cycle redirect to handler |
| redir_vec | output | 8 | Handler vector |
| redir_kind | output | 2 | 0 fault, 1 trap, 2 abort, 3 interrupt |
| redir_ret | output | AW | Return address to save |
| ret_valid | output | 1 | Return address is usable |

## Verification
The hardest situations to reach are the ones where an interrupt loses and must survive to a later boundary. The cases are a latched non-maskable request losing to a software trap, a maskable request losing to a fault or to the non-maskable request, and a second non-maskable request arriving while the first is still blocked. Directed sequences first load the pending state with a pulse on `nmi_in` in a cycle with no boundary. They then present competing exceptions at a boundary, follow that with empty boundaries and an `iret` pulse, and check at each step which event comes out. A sweep over 256 lane patterns, in which pairs of lanes share a class, covers the class ordering and the vector tie-break.

// File: rtl/iea_pkg.sv
package iea_pkg;
  localparam int VEC_W = 8;
  localparam logic [VEC_W-1:0] NMI_VECTOR = 8'd2;

  typedef enum logic [1:0] {
    CLS_ABORT = 2'd0,
    CLS_FAULT = 2'd1,
    CLS_DTRAP = 2'd2,
    CLS_STRAP = 2'd3
  } exc_cls_e;

  typedef enum logic [1:0] {
    RK_FAULT = 2'd0,
    RK_TRAP  = 2'd1,
    RK_ABORT = 2'd2,
    RK_IRQ   = 2'd3
  } redir_kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_ACK  = 1'b1
  } arb_st_e;
endpackage

// File: rtl/iea_exc_pick.sv
module iea_exc_pick #(
  parameter int N_EXC = 4
) (
  input  logic [N_EXC-1:0]                 valid,
  input  logic [2*N_EXC-1:0]               cls_flat,
  input  logic [iea_pkg::VEC_W*N_EXC-1:0]  vec_flat,
  output logic                             any,
  output logic [1:0]                       win_cls,
  output logic [iea_pkg::VEC_W-1:0]        win_vec
);
  localparam int KW = 2 + iea_pkg::VEC_W;

  logic [KW-1:0] key [N_EXC];

  // Sort key: class rank above vector, so a smaller key means higher priority.
  genvar g;
  generate
    for (g = 0; g < N_EXC; g++) begin : g_key
      assign key[g] = {cls_flat[2*g +: 2], vec_flat[iea_pkg::VEC_W*g +: iea_pkg::VEC_W]};
    end
  endgenerate

  logic [KW-1:0] best;
  logic          found;

  always_comb begin
    found = 1'b0;
    best  = '1;
    for (int i = 0; i < N_EXC; i++) begin
      if (valid[i] && (!found || key[i] < best)) begin
        found = 1'b1;
        best  = key[i];
      end
    end
  end

  assign any     = found;
  assign win_cls = best[KW-1 -: 2];
  assign win_vec = best[iea_pkg::VEC_W-1:0];
endmodule

// File: rtl/iea_nmi_track.sv
module iea_nmi_track (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic take,
  input  logic iret,
  output logic eligible
);
  logic pend_q, pend_d;
  logic blk_q, blk_d;

  always_comb begin
    pend_d = nmi_in | (pend_q & ~take);
    blk_d  = take | (blk_q & ~iret);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      blk_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      blk_q  <= blk_d;
    end
  end

  assign eligible = pend_q & ~blk_q;
endmodule

// File: rtl/iea_ret_sel.sv
module iea_ret_sel #(
  parameter int AW = 32
) (
  input  logic [1:0]    cls,
  input  logic [AW-1:0] cur_pc,
  input  logic [AW-1:0] next_pc,
  output logic [1:0]    kind,
  output logic [AW-1:0] ret,
  output logic          ret_ok
);
  import iea_pkg::*;

  always_comb begin
    unique case (exc_cls_e'(cls))
      CLS_ABORT: begin kind = RK_ABORT; ret = '0;      ret_ok = 1'b0; end
      CLS_FAULT: begin kind = RK_FAULT; ret = cur_pc;  ret_ok = 1'b1; end
      default:   begin kind = RK_TRAP;  ret = next_pc; ret_ok = 1'b1; end
    endcase
  end
endmodule

// File: rtl/irq_exc_arbiter.sv
module irq_exc_arbiter #(
  parameter int N_EXC = 4,
  parameter int AW    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 boundary,
  input  logic [AW-1:0]        cur_pc,
  input  logic [AW-1:0]        next_pc,
  input  logic [N_EXC-1:0]     exc_valid,
  input  logic [2*N_EXC-1:0]   exc_class,
  input  logic [8*N_EXC-1:0]   exc_vec,
  input  logic                 nmi_in,
  input  logic                 intr_in,
  input  logic                 if_flag,
  input  logic                 iret,
  output logic                 ack_req,
  input  logic                 vec_valid,
  input  logic [7:0]           vec_in,
  output logic                 redirect,
  output logic [7:0]           redir_vec,
  output logic [1:0]           redir_kind,
  output logic [AW-1:0]        redir_ret,
  output logic                 ret_valid
);
  import iea_pkg::*;

  arb_st_e st_q, st_d;

  logic            exc_any;
  logic [1:0]      win_cls;
  logic [VEC_W-1:0] win_vec;
  logic [1:0]      exc_kind;
  logic [AW-1:0]   exc_ret;
  logic            exc_ret_ok;
  logic            nmi_elig;

  logic idle, at_bnd, take_exc, take_nmi, take_intr, ack_done;

  logic [AW-1:0]    saved_ret_q, saved_ret_d;
  logic             redir_q, redir_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic [1:0]       kind_q, kind_d;
  logic [AW-1:0]    ret_q, ret_d;
  logic             rok_q, rok_d;
  logic             pay_en;

  iea_exc_pick #(.N_EXC(N_EXC)) u_pick (
    .valid    (exc_valid),
    .cls_flat (exc_class),
    .vec_flat (exc_vec),
    .any      (exc_any),
    .win_cls  (win_cls),
    .win_vec  (win_vec)
  );

  iea_ret_sel #(.AW(AW)) u_ret (
    .cls     (win_cls),
    .cur_pc  (cur_pc),
    .next_pc (next_pc),
    .kind    (exc_kind),
    .ret     (exc_ret),
    .ret_ok  (exc_ret_ok)
  );

  iea_nmi_track u_nmi (
    .clk      (clk),
    .rst_n    (rst_n),
    .nmi_in   (nmi_in),
    .take     (take_nmi),
    .iret     (iret),
    .eligible (nmi_elig)
  );

  // Selection at the instruction boundary; interrupts only if no exception.
  always_comb begin
    idle      = (st_q == ST_IDLE);
    at_bnd    = boundary & idle;
    take_exc  = at_bnd & exc_any;
    take_nmi  = at_bnd & ~exc_any & nmi_elig;
    take_intr = at_bnd & ~exc_any & ~nmi_elig & intr_in & if_flag;
    ack_done  = (st_q == ST_ACK) & vec_valid;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (take_intr) st_d = ST_ACK;
      ST_ACK:  if (vec_valid) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    saved_ret_d = take_intr ? next_pc : saved_ret_q;
    redir_d     = take_exc | take_nmi | ack_done;
    pay_en      = redir_d;
    vec_d       = vec_q;
    kind_d      = kind_q;
    ret_d       = ret_q;
    rok_d       = rok_q;
    if (take_exc) begin
      vec_d  = win_vec;
      kind_d = exc_kind;
      ret_d  = exc_ret;
      rok_d  = exc_ret_ok;
    end else if (take_nmi) begin
      vec_d  = NMI_VECTOR;
      kind_d = RK_IRQ;
      ret_d  = next_pc;
      rok_d  = 1'b1;
    end else if (ack_done) begin
      vec_d  = vec_in;
      kind_d = RK_IRQ;
      ret_d  = saved_ret_q;
      rok_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      redir_q     <= 1'b0;
      saved_ret_q <= '0;
      vec_q       <= '0;
      kind_q      <= '0;
      ret_q       <= '0;
      rok_q       <= 1'b0;
    end else begin
      st_q    <= st_d;
      redir_q <= redir_d;
      if (take_intr) saved_ret_q <= saved_ret_d;
      if (pay_en) begin
        vec_q  <= vec_d;
        kind_q <= kind_d;
        ret_q  <= ret_d;
        rok_q  <= rok_d;
      end
    end
  end

  assign ack_req    = (st_q == ST_ACK);
  assign redirect   = redir_q;
  assign redir_vec  = vec_q;
  assign redir_kind = kind_q;
  assign redir_ret  = ret_q;
  assign ret_valid  = rok_q;
endmodule

// File: rtl/iea_chk.sv
module iea_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          boundary,
  input logic          if_flag,
  input logic          ack_req,
  input logic          vec_valid,
  input logic [7:0]    vec_in,
  input logic          redirect,
  input logic [7:0]    redir_vec,
  input logic [1:0]    redir_kind,
  input logic [AW-1:0] redir_ret,
  input logic          ret_valid
);
  // R9
  abort_noret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && redir_kind == 2'd2) |-> (!ret_valid && redir_ret == '0));

  // R5
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !vec_valid) |=> (ack_req && !redirect));

  // R5
  ack_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && vec_valid) |=> (redirect && !ack_req && redir_vec == $past(vec_in) && redir_kind == 2'd3));

  // R4
  intr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_req && !if_flag) |=> !ack_req);

  // R1
  bnd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!boundary && !(ack_req && vec_valid)) |=> !redirect);

  // R8
  ret_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && redir_kind != 2'd2) |-> ret_valid);
endmodule

bind irq_exc_arbiter iea_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .boundary   (boundary),
  .if_flag    (if_flag),
  .ack_req    (ack_req),
  .vec_valid  (vec_valid),
  .vec_in     (vec_in),
  .redirect   (redirect),
  .redir_vec  (redir_vec),
  .redir_kind (redir_kind),
  .redir_ret  (redir_ret),
  .ret_valid  (ret_valid)
);

// File: tb/tb_irq_exc_arbiter.sv
`timescale 1ns/1ps
module tb_irq_exc_arbiter;
  localparam int N  = 4;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic boundary;
  logic [AW-1:0] cur_pc, next_pc;
  logic [N-1:0] exc_valid;
  logic [2*N-1:0] exc_class;
  logic [8*N-1:0] exc_vec;
  logic nmi_in, intr_in, if_flag, iret, vec_valid;
  logic [7:0] vec_in;
  logic ack_req, redirect, ret_valid;
  logic [7:0] redir_vec;
  logic [1:0] redir_kind;
  logic [AW-1:0] redir_ret;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  irq_exc_arbiter #(.N_EXC(N), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .cur_pc(cur_pc), .next_pc(next_pc),
    .exc_valid(exc_valid), .exc_class(exc_class), .exc_vec(exc_vec),
    .nmi_in(nmi_in), .intr_in(intr_in), .if_flag(if_flag), .iret(iret),
    .ack_req(ack_req), .vec_valid(vec_valid), .vec_in(vec_in),
    .redirect(redirect), .redir_vec(redir_vec), .redir_kind(redir_kind),
    .redir_ret(redir_ret), .ret_valid(ret_valid)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clr();
    boundary = 0; exc_valid = '0; exc_class = '0; exc_vec = '0;
    nmi_in = 0; intr_in = 0; if_flag = 0; iret = 0; vec_valid = 0; vec_in = '0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_lane(input int i, input logic [1:0] c, input logic [7:0] v);
    exc_valid[i] = 1'b1;
    exc_class[2*i +: 2] = c;
    exc_vec[8*i +: 8] = v;
  endtask

  task automatic check_redir(input string req, input logic [7:0] v, input logic [1:0] k,
                             input logic [AW-1:0] r, input logic ok);
    chk(req, "redirect", redirect, 1);
    chk(req, "vector", redir_vec, v);
    chk(req, "kind", redir_kind, k);
    chk(req, "ret", redir_ret, r);
    chk(req, "ret_valid", ret_valid, ok);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    clr();
    cur_pc = '0; next_pc = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    // R11 reset state
    chk("R11", "redirect", redirect, 0);
    chk("R11", "ack_req", ack_req, 0);
    // R11 nothing pending or blocked: an empty boundary yields nothing
    boundary = 1; next_pc = 32'h40;
    step(); boundary = 0;
    chk("R11", "no event after reset", redirect, 0);

    // R2 R3 R8 R9 sweep; lanes 0,1 and 2,3 share a class
    for (int code = 0; code < 256; code++) begin
      logic [1:0] c [N];
      logic [7:0] v [N];
      logic [9:0] best;
      bit found;
      logic [1:0] ek; logic [AW-1:0] er; logic eok;
      clr();
      cur_pc  = 32'h1000 + code * 4;
      next_pc = cur_pc + 4;
      found = 0; best = '1;
      for (int i = 0; i < N; i++) begin
        c[i] = 2'(((code >> 4) + i / 2) % 4);
        v[i] = 8'((code * 29 + i * 71) % 256);
        if (code[i]) begin
          set_lane(i, c[i], v[i]);
          if (!found || {c[i], v[i]} < best) begin found = 1; best = {c[i], v[i]}; end
        end
      end
      boundary = 1;
      step();
      clr();
      chk("R2", "redirect present", redirect, found);
      if (found) begin
        case (best[9:8])
          2'd0: begin ek = 2'd2; er = '0; eok = 0; end
          2'd1: begin ek = 2'd0; er = cur_pc; eok = 1; end
          default: begin ek = 2'd1; er = next_pc; eok = 1; end
        endcase
        chk("R3", "winning vector", redir_vec, best[7:0]);
        chk("R2", "winning kind", redir_kind, ek);
        chk(best[9:8] == 0 ? "R9" : "R8", "ret", redir_ret, er);
        chk(best[9:8] == 0 ? "R9" : "R8", "ret_valid", ret_valid, eok);
      end
    end

    // R1 exception without boundary is not taken
    clr(); set_lane(0, 2'd1, 8'h0E);
    step(); step();
    chk("R1", "no redirect without boundary", redirect, 0);
    clr(); step();

    // R4 masked INTR
    intr_in = 1; if_flag = 0; boundary = 1; next_pc = 32'h2000;
    step(); boundary = 0;
    chk("R4", "no ack when masked", ack_req, 0);
    chk("R4", "no redirect when masked", redirect, 0);
    step();
    chk("R4", "still no ack", ack_req, 0);
    clr(); step();

    // R5 handshake with boundaries ignored during ACK
    intr_in = 1; if_flag = 1; boundary = 1; next_pc = 32'h3000; cur_pc = 32'h2FFC;
    step();
    intr_in = 0; next_pc = 32'h5555;
    chk("R5", "ack_req raised", ack_req, 1);
    chk("R5", "no redirect yet", redirect, 0);
    set_lane(0, 2'd1, 8'h0D); boundary = 1;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R5", "held ack", ack_req, 1);
      chk("R5", "ignored boundary", redirect, 0);
    end
    clr(); vec_valid = 1; vec_in = 8'h41;
    step(); clr();
    check_redir("R5", 8'h41, 2'd3, 32'h3000, 1);
    chk("R5", "ack dropped", ack_req, 0);
    step();
    chk("R5", "single pulse", redirect, 0);

    // R6 NMI, R7 block and pending
    nmi_in = 1; step(); nmi_in = 0;
    boundary = 1; next_pc = 32'h4000;
    step(); boundary = 0;
    check_redir("R6", 8'd2, 2'd3, 32'h4000, 1);
    chk("R6", "no ack for nmi", ack_req, 0);
    nmi_in = 1; step(); nmi_in = 0;
    boundary = 1; next_pc = 32'h4100;
    step(); boundary = 0;
    chk("R7", "blocked nmi", redirect, 0);
    iret = 1; step(); iret = 0;
    boundary = 1; next_pc = 32'h4200;
    step(); boundary = 0;
    check_redir("R7", 8'd2, 2'd3, 32'h4200, 1);
    iret = 1; step(); iret = 0;

    // R2 R10 software trap beats pending NMI; NMI taken later
    nmi_in = 1; step(); nmi_in = 0;
    set_lane(1, 2'd3, 8'h80); boundary = 1; cur_pc = 32'h5000; next_pc = 32'h5002;
    step(); clr();
    check_redir("R2", 8'h80, 2'd1, 32'h5002, 1);
    boundary = 1; next_pc = 32'h5010;
    step(); boundary = 0;
    check_redir("R10", 8'd2, 2'd3, 32'h5010, 1);

    // R2 NMI beats INTR; R10 INTR kept (NMI still blocked)
    iret = 1; step(); iret = 0;
    nmi_in = 1; step(); nmi_in = 0;
    intr_in = 1; if_flag = 1; boundary = 1; next_pc = 32'h6000;
    step(); boundary = 0;
    check_redir("R2", 8'd2, 2'd3, 32'h6000, 1);
    chk("R2", "intr not acked", ack_req, 0);
    // fault beats INTR
    set_lane(2, 2'd1, 8'h0E); boundary = 1; cur_pc = 32'h6100; next_pc = 32'h6104;
    step(); exc_valid = '0; boundary = 0;
    check_redir("R8", 8'h0E, 2'd0, 32'h6100, 1);
    chk("R10", "intr not acked behind fault", ack_req, 0);
    boundary = 1; next_pc = 32'h6200;
    step(); boundary = 0; intr_in = 0;
    chk("R10", "intr taken later", ack_req, 1);
    vec_valid = 1; vec_in = 8'h20;
    step(); clr();
    check_redir("R10", 8'h20, 2'd3, 32'h6200, 1);
    iret = 1; step(); iret = 0;

    // R10 losing exception discarded
    set_lane(0, 2'd2, 8'h01); set_lane(3, 2'd1, 8'h0B); boundary = 1;
    cur_pc = 32'h7000; next_pc = 32'h7004;
    step(); clr();
    check_redir("R10", 8'h0B, 2'd0, 32'h7000, 1);
    boundary = 1;
    step(); boundary = 0;
    chk("R10", "loser discarded", redirect, 0);

    // R3 tie on equal class: lower vector in higher lane index still wins
    set_lane(0, 2'd2, 8'h30); set_lane(3, 2'd2, 8'h10); boundary = 1;
    step(); clr();
    chk("R3", "lower vector wins", redir_vec, 8'h10);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule